// File: doc/BRIEF.md
# System Power Mode Controller

This block chooses the operating mode of a system with two processors, a CPU and a DSP, that share buses, a group of PLLs and an SDRAM. It drives the clock enables of each domain, the select between the reference clock and the PLL outputs, the PLL power-down lines and the SDRAM self-refresh request. There are five modes: normal, slow, idle, sleep and stop.

Software asks for a mode with a one-cycle request strobe that carries a mode code. Hardware wake events bring the system back to normal. Each low-power mode listens to its own class of wake event.

Stop mode is entered and left through handshakes. On the way in, the block waits for the memory to acknowledge self-refresh. On the way out, it waits for PLL lock and then for the memory to drop its acknowledge. A request that arrives while the controller is outside normal mode is held and carried out once normal mode is reached. Every output comes from a flop clocked by the reference clock.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in normal mode. The CPU, DSP and bus clock enables are all 1, `clk_sel_pll`=1, all `pll_pd`=0, `sr_req`=0, `mode_status`=0 and `busy`=0.
- R2: In normal mode, a `req_valid` strobe with `req_mode` 0 to 4 selects normal(0), slow(1), idle(2), sleep(3) or stop(4), and the outputs change at the next edge. Codes 5 to 7 are ignored and are not stored.
- R3: Slow mode has `clk_sel_pll`=0, all clocks on and status 1. A request for normal moves to an exit step (status 1, `busy`=1, still on the reference clock). That step passes to normal only on an edge where `pll_lock`=1.
- R4: Idle mode gates only the CPU clock (status 2). Only `cpu_irq` returns it to normal. `dsp_irq`, `sw_wake`, `ext_wake` and `rtc_alarm` have no effect in idle.
- R5: Sleep mode gates only the DSP clock (status 3). `dsp_irq` or `sw_wake` returns it to normal. `cpu_irq`, `ext_wake` and `rtc_alarm` have no effect in sleep.
- R6: A stop request first raises `sr_req` with all clocks still on (status 4, `busy`=1). Only on an edge with `sr_ack`=1 does the block enter stop. In stop, all clock enables are 0, `clk_sel_pll`=0, every `pll_pd`=1, `sr_req`=1 and `busy`=0.
- R7: In stop, only `ext_wake` or `rtc_alarm` starts the exit. `cpu_irq`, `dsp_irq` and `sw_wake` have no effect.
- R8: The stop exit runs in order. First the PLLs are powered up, with clocks still off, `clk_sel_pll`=0, `sr_req`=1 and `busy`=1, until an edge with `pll_lock`=1. Next comes a release step with `clk_sel_pll`=1, `sr_req`=0, clocks still off and `busy`=1, until an edge with `sr_ack`=0. Then the block is in normal.
- R9: A legal request made outside normal mode is held, and a later one replaces it. The held request is carried out on the first edge after normal is reached, so normal lasts one cycle. A request for normal made in slow mode is taken at once.
- R10: `mode_status` always shows the mode that has been entered or is being entered (4 for every stop step). `busy` is 1 only during the handshake and exit steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Software mode request strobe |
| req_mode | input | 3 | Requested mode code |
| sw_wake | input | 1 | Software wake write from the CPU |
| cpu_irq | input | 1 | Summary of interrupts routed to the CPU |
| dsp_irq | input | 1 | Summary of interrupts routed to the DSP |
| ext_wake | input | 1 | External wake pin, synchronous |
| rtc_alarm | input | 1 | Real-time clock alarm |
| pll_lock | input | 1 | All PLLs locked |
| sr_ack | input | 1 | SDRAM self-refresh acknowledge |
| cpu_clk_en | output | 1 | CPU clock enable |
| dsp_clk_en | output | 1 | DSP clock enable |
| bus_clk_en | output | NUM_BUS | Bus clock enables |
| clk_sel_pll | output | 1 | 1 selects the PLL clocks, 0 the reference clock |
| pll_pd | output | NUM_PLL | PLL power-down lines |
| sr_req | output | 1 | Self-refresh request |
| mode_status | output | 3 | Current mode code |
| busy | output | 1 | Transition in progress |

## Verification
The properties assume that every input is synchronous to the reference clock. They also assume that `pll_lock` reflects the PLLs' real state and that `sr_ack` follows `sr_req` as a level handshake.

The stimulus drives all inputs half a cycle away from the active edge. It lowers `pll_lock` whenever the PLLs are powered down. It raises and drops `sr_ack` only while the matching request is in place.

Random wake vectors are applied in idle, sleep and stop. This checks that each mode ignores every event outside its own wake class.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MD_NORMAL = 3'd0;
  localparam logic [MODE_W-1:0] MD_SLOW   = 3'd1;
  localparam logic [MODE_W-1:0] MD_IDLE   = 3'd2;
  localparam logic [MODE_W-1:0] MD_SLEEP  = 3'd3;
  localparam logic [MODE_W-1:0] MD_STOP   = 3'd4;

  typedef enum logic [3:0] {
    ST_NORMAL     = 4'd0,
    ST_SLOW       = 4'd1,
    ST_SLOW_EXIT  = 4'd2,
    ST_IDLE       = 4'd3,
    ST_SLEEP      = 4'd4,
    ST_STOP_ENTER = 4'd5,
    ST_STOP       = 4'd6,
    ST_STOP_LOCK  = 4'd7,
    ST_STOP_REL   = 4'd8
  } pmc_state_e;

  typedef struct packed {
    logic              cpu_en;
    logic              dsp_en;
    logic              bus_en;
    logic              sel_pll;
    logic              pll_pd;
    logic              sr_req;
    logic [MODE_W-1:0] status;
    logic              busy;
  } pmc_ctl_t;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return (m <= MD_STOP);
  endfunction

  // Output set of every state; fields: cpu dsp bus sel pd sr status busy
  function automatic pmc_ctl_t ctl_of(input pmc_state_e s);
    pmc_ctl_t c;
    unique case (s)
      ST_NORMAL:     c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, MD_NORMAL, 1'b0};
      ST_SLOW:       c = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, MD_SLOW,   1'b0};
      ST_SLOW_EXIT:  c = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, MD_SLOW,   1'b1};
      ST_IDLE:       c = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, MD_IDLE,   1'b0};
      ST_SLEEP:      c = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, MD_SLEEP,  1'b0};
      ST_STOP_ENTER: c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, MD_STOP,   1'b1};
      ST_STOP:       c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, MD_STOP,   1'b0};
      ST_STOP_LOCK:  c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, MD_STOP,   1'b1};
      ST_STOP_REL:   c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, MD_STOP,   1'b1};
      default:       c = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, MD_NORMAL, 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pmc_wake_sel.sv
module pmc_wake_sel
  import pmc_pkg::*;
(
  input  pmc_state_e state,
  input  logic       cpu_irq,
  input  logic       dsp_irq,
  input  logic       sw_wake,
  input  logic       ext_wake,
  input  logic       rtc_alarm,
  output logic       wake
);

  // Each low-power mode listens only to its own class of event
  always_comb begin
    unique case (state)
      ST_IDLE:  wake = cpu_irq;
      ST_SLEEP: wake = dsp_irq | sw_wake;
      ST_STOP:  wake = ext_wake | rtc_alarm;
      default:  wake = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmc_req_hold.sv
module pmc_req_hold
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              accept,
  input  logic              take,
  output logic              pend_valid,
  output logic [MODE_W-1:0] pend_mode
);

  logic              capture;
  logic              pend_valid_nxt;
  logic [MODE_W-1:0] pend_mode_nxt;

  assign capture = req_valid && mode_legal(req_mode) && !accept;

  always_comb begin
    pend_valid_nxt = pend_valid;
    pend_mode_nxt  = pend_mode;
    if (take) begin
      pend_valid_nxt = 1'b0;
    end
    if (capture) begin
      pend_valid_nxt = 1'b1;
      pend_mode_nxt  = req_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_mode  <= MD_NORMAL;
    end else begin
      pend_valid <= pend_valid_nxt;
      pend_mode  <= pend_mode_nxt;
    end
  end

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              pend_valid,
  input  logic [MODE_W-1:0] pend_mode,
  input  logic              wake,
  input  logic              pll_lock,
  input  logic              sr_ack,
  output pmc_state_e        state_nxt,
  output logic              accept,
  output logic              take
);

  pmc_state_e        state_q;
  logic              cmd_ok;
  logic [MODE_W-1:0] cmd;
  logic              req_ok;

  assign req_ok = req_valid && mode_legal(req_mode);

  always_comb begin
    state_nxt = state_q;
    accept    = 1'b0;
    take      = 1'b0;
    cmd_ok    = 1'b0;
    cmd       = MD_NORMAL;
    unique case (state_q)
      ST_NORMAL: begin
        if (req_ok) begin
          cmd_ok = 1'b1;
          cmd    = req_mode;
          accept = 1'b1;
          take   = pend_valid;
        end else if (pend_valid) begin
          cmd_ok = 1'b1;
          cmd    = pend_mode;
          take   = 1'b1;
        end
        if (cmd_ok) begin
          unique case (cmd)
            MD_SLOW:  state_nxt = ST_SLOW;
            MD_IDLE:  state_nxt = ST_IDLE;
            MD_SLEEP: state_nxt = ST_SLEEP;
            MD_STOP:  state_nxt = ST_STOP_ENTER;
            default:  state_nxt = ST_NORMAL;
          endcase
        end
      end
      ST_SLOW: begin
        if (req_ok && (req_mode == MD_NORMAL)) begin
          accept    = 1'b1;
          state_nxt = ST_SLOW_EXIT;
        end
      end
      ST_SLOW_EXIT: begin
        if (pll_lock) state_nxt = ST_NORMAL;
      end
      ST_IDLE, ST_SLEEP: begin
        if (wake) state_nxt = ST_NORMAL;
      end
      ST_STOP_ENTER: begin
        if (sr_ack) state_nxt = ST_STOP;
      end
      ST_STOP: begin
        if (wake) state_nxt = ST_STOP_LOCK;
      end
      ST_STOP_LOCK: begin
        if (pll_lock) state_nxt = ST_STOP_REL;
      end
      ST_STOP_REL: begin
        if (!sr_ack) state_nxt = ST_NORMAL;
      end
      default: state_nxt = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
    end else begin
      state_q <= state_nxt;
    end
  end

endmodule

// File: rtl/pmc_out_reg.sv
module pmc_out_reg
  import pmc_pkg::*;
#(
  parameter int NUM_BUS = 2,
  parameter int NUM_PLL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pmc_state_e         state_nxt,
  output pmc_state_e         state_cur,
  output logic               cpu_clk_en,
  output logic               dsp_clk_en,
  output logic [NUM_BUS-1:0] bus_clk_en,
  output logic               clk_sel_pll,
  output logic [NUM_PLL-1:0] pll_pd,
  output logic               sr_req,
  output logic [MODE_W-1:0]  mode_status,
  output logic               busy
);

  localparam pmc_ctl_t RST_CTL = ctl_of(ST_NORMAL);

  pmc_ctl_t ctl_nxt;
  pmc_ctl_t ctl_q;

  assign ctl_nxt = ctl_of(state_nxt);

  // The current state is kept here so the wake selector follows the outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_cur <= ST_NORMAL;
      ctl_q     <= RST_CTL;
    end else begin
      state_cur <= state_nxt;
      ctl_q     <= ctl_nxt;
    end
  end

  // One flop per bus enable so each domain gets a clean edge-aligned enable
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic en_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= RST_CTL.bus_en;
      else        en_q <= ctl_nxt.bus_en;
    end
    assign bus_clk_en[b] = en_q;
  end

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
    logic pd_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pd_q <= RST_CTL.pll_pd;
      else        pd_q <= ctl_nxt.pll_pd;
    end
    assign pll_pd[p] = pd_q;
  end

  assign cpu_clk_en  = ctl_q.cpu_en;
  assign dsp_clk_en  = ctl_q.dsp_en;
  assign clk_sel_pll = ctl_q.sel_pll;
  assign sr_req      = ctl_q.sr_req;
  assign mode_status = ctl_q.status;
  assign busy        = ctl_q.busy;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_BUS = 2,
  parameter int NUM_PLL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [2:0]         req_mode,
  input  logic               sw_wake,
  input  logic               cpu_irq,
  input  logic               dsp_irq,
  input  logic               ext_wake,
  input  logic               rtc_alarm,
  input  logic               pll_lock,
  input  logic               sr_ack,
  output logic               cpu_clk_en,
  output logic               dsp_clk_en,
  output logic [NUM_BUS-1:0] bus_clk_en,
  output logic               clk_sel_pll,
  output logic [NUM_PLL-1:0] pll_pd,
  output logic               sr_req,
  output logic [2:0]         mode_status,
  output logic               busy
);

  logic              rst_n_int;
  pmc_state_e        state_nxt;
  pmc_state_e        state_cur;
  logic              wake;
  logic              accept;
  logic              take;
  logic              pend_valid;
  logic [MODE_W-1:0] pend_mode;

  pmc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  pmc_wake_sel u_wake (
    .state     (state_cur),
    .cpu_irq   (cpu_irq),
    .dsp_irq   (dsp_irq),
    .sw_wake   (sw_wake),
    .ext_wake  (ext_wake),
    .rtc_alarm (rtc_alarm),
    .wake      (wake)
  );

  pmc_req_hold u_hold (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .accept     (accept),
    .take       (take),
    .pend_valid (pend_valid),
    .pend_mode  (pend_mode)
  );

  pmc_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .pend_valid (pend_valid),
    .pend_mode  (pend_mode),
    .wake       (wake),
    .pll_lock   (pll_lock),
    .sr_ack     (sr_ack),
    .state_nxt  (state_nxt),
    .accept     (accept),
    .take       (take)
  );

  pmc_out_reg #(.NUM_BUS(NUM_BUS), .NUM_PLL(NUM_PLL)) u_out (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .state_nxt   (state_nxt),
    .state_cur   (state_cur),
    .cpu_clk_en  (cpu_clk_en),
    .dsp_clk_en  (dsp_clk_en),
    .bus_clk_en  (bus_clk_en),
    .clk_sel_pll (clk_sel_pll),
    .pll_pd      (pll_pd),
    .sr_req      (sr_req),
    .mode_status (mode_status),
    .busy        (busy)
  );

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int NUM_BUS = 2,
  parameter int NUM_PLL = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sw_wake,
  input logic               cpu_irq,
  input logic               dsp_irq,
  input logic               ext_wake,
  input logic               rtc_alarm,
  input logic               pll_lock,
  input logic               sr_ack,
  input logic               cpu_clk_en,
  input logic               dsp_clk_en,
  input logic [NUM_BUS-1:0] bus_clk_en,
  input logic               clk_sel_pll,
  input logic [NUM_PLL-1:0] pll_pd,
  input logic               sr_req,
  input logic [2:0]         mode_status,
  input logic               busy
);

  // R4: idle holds the CPU clock off until a CPU interrupt
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_clk_en && dsp_clk_en && !cpu_irq) |=> !cpu_clk_en);

  // R5: sleep holds the DSP clock off without a DSP-class wake
  a_r5_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && !dsp_clk_en && !dsp_irq && !sw_wake) |=> !dsp_clk_en);

  // R6: PLLs power down only after the self-refresh acknowledge
  a_r6_pd_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_pd[0]) |-> (sr_req && $past(sr_ack)));

  // R6: with PLLs down every clock is gated and the reference is selected
  a_r6_pd_clocks_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_pd != '0) |-> (!cpu_clk_en && !dsp_clk_en && (bus_clk_en == '0) && !clk_sel_pll));

  // R7: stop is left only through the external pin or the RTC alarm
  a_r7_stop_wake_class: assert property (@(posedge clk) disable iff (!rst_n)
    ((pll_pd != '0) && !ext_wake && !rtc_alarm) |=> (pll_pd != '0));

  // R8: self-refresh is released only after lock
  a_r8_sr_release_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_req) |-> ($past(pll_lock) && (pll_pd == '0)));

  // R3, R8: return to the PLL clocks only with lock
  a_r8_sel_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel_pll) |-> $past(pll_lock));

  // R10: transitions never report the normal mode
  a_r10_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode_status != 3'd0));

endmodule

bind pwr_mode_ctrl pmc_checker #(.NUM_BUS(NUM_BUS), .NUM_PLL(NUM_PLL)) u_chk (.*);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;

  localparam int NB = 2;
  localparam int NP = 3;

  localparam int K_NORMAL = 0, K_SLOW = 1, K_SLOWX = 2, K_IDLE = 3, K_SLEEP = 4;
  localparam int K_STOPE = 5, K_STOP = 6, K_STOPL = 7, K_STOPR = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, sw_wake, cpu_irq, dsp_irq, ext_wake, rtc_alarm, pll_lock, sr_ack;
  logic [2:0] req_mode;
  logic cpu_clk_en, dsp_clk_en, clk_sel_pll, sr_req, busy;
  logic [NB-1:0] bus_clk_en;
  logic [NP-1:0] pll_pd;
  logic [2:0] mode_status;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.NUM_BUS(NB), .NUM_PLL(NP)) uut (.*);

  // Expected {cpu,dsp,bus,sel,pd,sr,status[2:0],busy} per the requirements
  function automatic logic [9:0] exp_of(input int k);
    case (k)
      K_NORMAL: return {6'b111100, 3'd0, 1'b0};
      K_SLOW:   return {6'b111000, 3'd1, 1'b0};
      K_SLOWX:  return {6'b111000, 3'd1, 1'b1};
      K_IDLE:   return {6'b011100, 3'd2, 1'b0};
      K_SLEEP:  return {6'b101100, 3'd3, 1'b0};
      K_STOPE:  return {6'b111101, 3'd4, 1'b1};
      K_STOP:   return {6'b000011, 3'd4, 1'b0};
      K_STOPL:  return {6'b000001, 3'd4, 1'b1};
      K_STOPR:  return {6'b000100, 3'd4, 1'b1};
      default:  return 10'bx;
    endcase
  endfunction

  function automatic logic [9:0] act_vec();
    logic b, p;
    b = (bus_clk_en == '1) ? 1'b1 : ((bus_clk_en == '0) ? 1'b0 : 1'bx);
    p = (pll_pd == '1) ? 1'b1 : ((pll_pd == '0) ? 1'b0 : 1'bx);
    return {cpu_clk_en, dsp_clk_en, b, clk_sel_pll, p, sr_req, mode_status, busy};
  endfunction

  task automatic chk(input string tag, input int k);
    logic [9:0] a, e;
    a = act_vec();
    e = exp_of(k);
    nchk++;
    if (a !== e) begin
      nfail++;
      $display("FAIL %s actual=%b expected=%b", tag, a, e);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic req(input logic [2:0] m);
    req_valid = 1'b1;
    req_mode  = m;
    step();
    req_valid = 1'b0;
  endtask

  task automatic wake_vec(input logic [4:0] w);
    {rtc_alarm, ext_wake, sw_wake, dsp_irq, cpu_irq} = w;
    step();
    {rtc_alarm, ext_wake, sw_wake, dsp_irq, cpu_irq} = 5'b0;
  endtask

  task automatic enter_stop();
    req(3'd4);
    chk("R6 stop entry request", K_STOPE);
    sr_ack = 1'b1;
    step();
    chk("R6 stop reached", K_STOP);
    pll_lock = 1'b0;
  endtask

  task automatic leave_stop_after_wake();
    chk("R8 lock wait", K_STOPL);
    pll_lock = 1'b1;
    step();
    chk("R8 release step", K_STOPR);
    sr_ack = 1'b0;
    step();
    chk("R8 back to normal", K_NORMAL);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [4:0] w;
    int m, seed;
    bit hit;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0;
    req_valid = 1'b0; req_mode = 3'd0;
    {rtc_alarm, ext_wake, sw_wake, dsp_irq, cpu_irq} = 5'b0;
    pll_lock = 1'b1; sr_ack = 1'b0;
    repeat (3) step();
    chk("R1 reset state", K_NORMAL);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 after release", K_NORMAL);

    // R2 illegal code ignored and not stored
    req(3'd6);
    chk("R2 illegal code", K_NORMAL);
    step();
    chk("R2 illegal code not held", K_NORMAL);

    // R3 slow mode with R9 hold of an idle request
    req(3'd1);
    chk("R3 slow entry", K_SLOW);
    req(3'd2);
    chk("R9 request held in slow", K_SLOW);
    pll_lock = 1'b0;
    req(3'd0);
    chk("R3 slow exit waits", K_SLOWX);
    step();
    chk("R3 slow exit no lock", K_SLOWX);
    pll_lock = 1'b1;
    step();
    chk("R3 slow exit to normal", K_NORMAL);
    step();
    chk("R9 held idle applied", K_IDLE);

    // R4 idle ignores the other events
    wake_vec(5'b11110);
    chk("R4 idle ignores others", K_IDLE);
    wake_vec(5'b00001);
    chk("R4 cpu irq wakes", K_NORMAL);

    // R5 sleep
    req(3'd3);
    chk("R5 sleep entry", K_SLEEP);
    wake_vec(5'b11001);
    chk("R5 sleep ignores others", K_SLEEP);
    req(3'd1);
    req(3'd2);
    chk("R9 requests held in sleep", K_SLEEP);
    wake_vec(5'b00100);
    chk("R5 sw wake", K_NORMAL);
    step();
    chk("R9 latest held request wins", K_IDLE);
    wake_vec(5'b00001);
    chk("R4 wake", K_NORMAL);

    // R6 R7 R8 stop handshake
    req(3'd4);
    chk("R6 ack pending", K_STOPE);
    step();
    chk("R6 clocks on until ack", K_STOPE);
    sr_ack = 1'b1;
    step();
    chk("R6 stop", K_STOP);
    pll_lock = 1'b0;
    wake_vec(5'b00111);
    chk("R7 stop ignores irqs", K_STOP);
    wake_vec(5'b10000);
    step();
    chk("R8 waits lock", K_STOPL);
    pll_lock = 1'b1;
    step();
    chk("R8 release", K_STOPR);
    step();
    chk("R8 waits ack drop", K_STOPR);
    sr_ack = 1'b0;
    step();
    chk("R8 normal again", K_NORMAL);

    // Random wake vectors across the low-power modes
    for (int it = 0; it < 40; it++) begin
      m = $urandom_range(0, 2);
      if (m == 0) begin
        req(3'd2); chk("R4 idle entry", K_IDLE);
      end else if (m == 1) begin
        req(3'd3); chk("R5 sleep entry", K_SLEEP);
      end else begin
        enter_stop();
      end
      hit = 1'b0;
      for (int c = 0; c < 6 && !hit; c++) begin
        w = 5'($urandom_range(0, 31));
        if (c == 5) w = (m == 0) ? 5'b00001 : ((m == 1) ? 5'b00010 : 5'b01000);
        hit = (m == 0) ? w[0] : ((m == 1) ? (w[1] | w[2]) : (w[3] | w[4]));
        wake_vec(w);
        if (m == 0)      chk("R4 random wake", hit ? K_NORMAL : K_IDLE);
        else if (m == 1) chk("R5 random wake", hit ? K_NORMAL : K_SLEEP);
        else if (hit)    leave_stop_after_wake();
        else             chk("R7 random wake", K_STOP);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule